// File: doc/BRIEF.md
# Prescaled Interval Timer with Event Flags

This block is a 32-bit interval timer clocked by a peripheral clock. A prescale counter divides the clock by a programmable amount. Each time the prescaler finishes its period, the timer counter advances by one. A two-bit control register starts, stops or clears the counting. Four compare channels raise a flag when the count reaches their programmed value. Four capture channels snapshot the count when a one-cycle strobe arrives and raise their own flag.

Software reaches the block through a simple synchronous register bus with byte offsets. It clears flags by writing ones to them. It receives a single interrupt line that is high whenever any flag is pending.

Top module: `ptmr_top`

## Requirements
- R1: After the active-low reset, all registers (flags, control, count, prescale, compare and capture values) read 0 and `irq` is 0.
- R2: Register offsets: flags at 0x00, control at 0x04, count at 0x08, prescale limit at 0x0C, compare value k at 0x10+4k, capture value k at 0x20+4k. Compare values read back what was written. Capture values are read-only, and bus writes to them have no effect. Reads are combinational from the address.
- R3: While enabled, the count advances once every P+1 clocks, where P is the prescale limit. The prescale counter returns to 0 in the same cycle the count advances. With P=0 the count advances every clock.
- R4: With control bit 0 (enable) at 0, the count and the prescale counter keep their values.
- R5: While control bit 1 (clear) is 1, both counters are forced to 0 at each rising edge, whatever the enable bit holds. Counting resumes from 0 once the bit returns to 0.
- R6: The count wraps from 0xFFFFFFFF to 0x00000000, and the wrap on its own sets no flag.
- R7: Compare channel k sets flag bit k on the edge where the count advances to a value equal to compare value k.
- R8: A one-cycle strobe on `cap_strobe[k]` stores the count present in that cycle into capture value k and sets flag bit 4+k.
- R9: Writing a 1 to a flag bit clears it. Writing a 0 leaves that bit unchanged.
- R10: If a hardware set and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R11: `irq` is 1 exactly when at least one flag bit is 1.
- R12: A control write takes effect on the following clock edge. After an enabling write with P=0, the count reads 0 right after the write edge and reads 1 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cap_strobe | input | 4 | One-cycle capture strobes, one per channel |
| irq | output | 1 | Combined interrupt, high while any flag is set |

## Verification
The assertions assume that reset is held low for at least one rising edge before any bus access or strobe. They also assume that every input changes only between clock edges, so each bus access and each strobe is seen by exactly one edge. The bench drives all inputs on the falling edge and releases them one clock later, which keeps every access and strobe to a single cycle. Collisions, such as a strobe arriving together with a flag-clearing write, are created on purpose by driving both in the same falling-edge window.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
// Shared constants for the prescaled timer: register offsets and channel counts.
// Assumes byte addressing with 32-bit registers on 4-byte strides.
package ptmr_pkg;
    localparam int unsigned OFF_FLAGS = 32'h00;
    localparam int unsigned OFF_CTRL  = 32'h04;
    localparam int unsigned OFF_COUNT = 32'h08;
    localparam int unsigned OFF_PRE   = 32'h0C;
    localparam int unsigned OFF_CMP   = 32'h10;
    localparam int unsigned OFF_CAP   = 32'h20;
    localparam int unsigned STRIDE    = 4;

    // Control register bit positions
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_CLR_BIT = 1;
endpackage

// File: rtl/ptmr_prescale.sv
`timescale 1ns/1ps
// Prescale divider: counts enabled clocks and emits a one-cycle tick on the
// terminal count, then restarts from zero. Assumes clr dominates en.
// A count above the limit (after the limit is lowered) is treated as terminal.
module ptmr_prescale #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic [W-1:0] pcount,
    output logic         tick
);
    logic at_term;

    // Terminal detection and tick generation
    always_comb begin
        at_term = (pcount >= limit);
        tick    = en && !clr && at_term;
    end

    // Prescale counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcount <= '0;
        end else if (clr) begin
            pcount <= '0;
        end else if (en) begin
            pcount <= at_term ? '0 : pcount + 1'b1;
        end
    end
endmodule

// File: rtl/ptmr_counter.sv
`timescale 1ns/1ps
// Main timer counter: cleared by clr, loadable from the bus, advanced by tick.
// Priority is clr, then load, then tick. Wraps naturally at the top value.
// Reports an advance event and the value it advances to.
module ptmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic [W-1:0] count_nxt,
    output logic         adv
);
    // Advance event and incremented value
    always_comb begin
        count_nxt = count + 1'b1;
        adv       = tick && !clr && !load;
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= count_nxt;
        end
    end
endmodule

// File: rtl/ptmr_events.sv
`timescale 1ns/1ps
// Compare and capture channels. Compare values are bus-writable. A compare
// hit is flagged when the counter advances onto a compare value. Capture
// registers latch the current count on a strobe. Assumes one-cycle strobes.
module ptmr_events #(
    parameter int W     = 32,
    parameter int N_CMP = 4,
    parameter int N_CAP = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CMP-1:0]           cmp_wr,
    input  logic [W-1:0]               wdata,
    input  logic [W-1:0]               count,
    input  logic [W-1:0]               count_nxt,
    input  logic                       adv,
    input  logic [N_CAP-1:0]           strobe,
    output logic [N_CMP-1:0][W-1:0]    cmp_val,
    output logic [N_CAP-1:0][W-1:0]    cap_val,
    output logic [N_CMP-1:0]           cmp_hit
);
    genvar k;
    generate
        for (k = 0; k < N_CMP; k++) begin : g_cmp
            // Compare value register for channel k
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cmp_val[k] <= '0;
                end else if (cmp_wr[k]) begin
                    cmp_val[k] <= wdata;
                end
            end
            // Hit when the counter is about to become the compare value
            always_comb begin
                cmp_hit[k] = adv && (count_nxt == cmp_val[k]);
            end
        end
        for (k = 0; k < N_CAP; k++) begin : g_cap
            // Capture register for channel k
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cap_val[k] <= '0;
                end else if (strobe[k]) begin
                    cap_val[k] <= count;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ptmr_flags.sv
`timescale 1ns/1ps
// Pending-event flag register with write-one-to-clear. A hardware set wins
// over a clear in the same cycle. Drives the combined interrupt line.
module ptmr_flags #(
    parameter int NF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flags,
    output logic          irq
);
    // Flag storage: clear first, then set on top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
        end
    end

    // Combined interrupt
    always_comb begin
        irq = |flags;
    end
endmodule

// File: rtl/ptmr_top.sv
`timescale 1ns/1ps
// Prescaled timer top: register bus decode, control register, read mux and
// wiring of prescaler, counter, event channels and flags. Flag bit order is
// compare channels in the low bits, capture channels above them.
// Assumes single-cycle bus accesses and synchronous active-low reset.
module ptmr_top #(
    parameter int W      = 32,
    parameter int ADDR_W = 8,
    parameter int N_CMP  = 4,
    parameter int N_CAP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [N_CAP-1:0]  cap_strobe,
    output logic              irq
);
    import ptmr_pkg::*;

    localparam int NF = N_CMP + N_CAP;
    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(OFF_FLAGS);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_PRE   = ADDR_W'(OFF_PRE);

    logic                    wr_any;
    logic                    wr_flags, wr_ctrl, wr_count, wr_pre;
    logic [N_CMP-1:0]        cmp_wr;
    logic                    ctrl_en_q, ctrl_clr_q;
    logic [W-1:0]            pre_q;
    logic [W-1:0]            pcount;
    logic                    tick;
    logic [W-1:0]            count, count_nxt;
    logic                    adv;
    logic [N_CMP-1:0][W-1:0] cmp_val;
    logic [N_CAP-1:0][W-1:0] cap_val;
    logic [N_CMP-1:0]        cmp_hit;
    logic [NF-1:0]           flag_set, flag_clr, flags;

    // Write decode for the fixed registers
    always_comb begin
        wr_any   = bus_sel && bus_wr;
        wr_flags = wr_any && (bus_addr == A_FLAGS);
        wr_ctrl  = wr_any && (bus_addr == A_CTRL);
        wr_count = wr_any && (bus_addr == A_COUNT);
        wr_pre   = wr_any && (bus_addr == A_PRE);
    end

    genvar g;
    generate
        for (g = 0; g < N_CMP; g++) begin : g_cmp_dec
            // Write decode for compare value g
            always_comb begin
                cmp_wr[g] = wr_any && (bus_addr == ADDR_W'(OFF_CMP + STRIDE * g));
            end
        end
    endgenerate

    // Control and prescale limit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en_q  <= 1'b0;
            ctrl_clr_q <= 1'b0;
            pre_q      <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en_q  <= bus_wdata[CTRL_EN_BIT];
                ctrl_clr_q <= bus_wdata[CTRL_CLR_BIT];
            end
            if (wr_pre) begin
                pre_q <= bus_wdata;
            end
        end
    end

    ptmr_prescale #(.W(W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctrl_clr_q),
        .en     (ctrl_en_q),
        .limit  (pre_q),
        .pcount (pcount),
        .tick   (tick)
    );

    ptmr_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctrl_clr_q),
        .load      (wr_count),
        .load_val  (bus_wdata),
        .tick      (tick),
        .count     (count),
        .count_nxt (count_nxt),
        .adv       (adv)
    );

    ptmr_events #(.W(W), .N_CMP(N_CMP), .N_CAP(N_CAP)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_wr    (cmp_wr),
        .wdata     (bus_wdata),
        .count     (count),
        .count_nxt (count_nxt),
        .adv       (adv),
        .strobe    (cap_strobe),
        .cmp_val   (cmp_val),
        .cap_val   (cap_val),
        .cmp_hit   (cmp_hit)
    );

    // Flag set and clear vectors
    always_comb begin
        flag_set = {cap_strobe, cmp_hit};
        flag_clr = wr_flags ? bus_wdata[NF-1:0] : '0;
    end

    ptmr_flags #(.NF(NF)) u_flg (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flags),
        .irq   (irq)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_FLAGS) begin
            bus_rdata[NF-1:0] = flags;
        end else if (bus_addr == A_CTRL) begin
            bus_rdata[CTRL_EN_BIT]  = ctrl_en_q;
            bus_rdata[CTRL_CLR_BIT] = ctrl_clr_q;
        end else if (bus_addr == A_COUNT) begin
            bus_rdata = count;
        end else if (bus_addr == A_PRE) begin
            bus_rdata = pre_q;
        end else begin
            for (int i = 0; i < N_CMP; i++) begin
                if (bus_addr == ADDR_W'(OFF_CMP + STRIDE * i)) bus_rdata = cmp_val[i];
            end
            for (int i = 0; i < N_CAP; i++) begin
                if (bus_addr == ADDR_W'(OFF_CAP + STRIDE * i)) bus_rdata = cap_val[i];
            end
        end
    end
endmodule

// File: rtl/ptmr_chk.sv
`timescale 1ns/1ps
// Assertion checker for the prescaled timer, bound into ptmr_top.
// Assumes inputs change only between clock edges.
module ptmr_chk #(
    parameter int W  = 32,
    parameter int NF = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_en,
    input logic          ctrl_clr,
    input logic          wr_count,
    input logic          wr_flags,
    input logic [NF-1:0] wdata_lo,
    input logic [W-1:0]  count,
    input logic [W-1:0]  pcount,
    input logic [NF-1:0] flags,
    input logic          strobe0,
    input logic [W-1:0]  cap0
);
    logic [NF-1:0] clr_v;

    // Clear mask seen by the flag register this cycle
    always_comb begin
        clr_v = wr_flags ? wdata_lo : '0;
    end

    AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_clr |=> (count == '0 && pcount == '0)); // R5

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !ctrl_clr && !wr_count) |=> ($stable(count) && $stable(pcount))); // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !ctrl_clr && !wr_count) |=> (count == $past(count) || count == $past(count) + 1'b1)); // R3

    AST_CAPTURE_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        strobe0 |=> (cap0 == $past(count) && flags[NF/2])); // R8

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~clr_v)) == $past(flags & ~clr_v))); // R9
endmodule

bind ptmr_top ptmr_chk #(.W(W), .NF(N_CMP + N_CAP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_en  (ctrl_en_q),
    .ctrl_clr (ctrl_clr_q),
    .wr_count (wr_count),
    .wr_flags (wr_flags),
    .wdata_lo (bus_wdata[N_CMP+N_CAP-1:0]),
    .count    (count),
    .pcount   (pcount),
    .flags    (flags),
    .strobe0  (cap_strobe[0]),
    .cap0     (cap_val[0])
);

// File: tb/ptmr_top_tb.sv
`timescale 1ns/1ps
// Directed bench for ptmr_top: one task per scenario, each checking its results.
module ptmr_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cap_strobe = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    localparam logic [7:0] A_FLAGS = 8'h00, A_CTRL = 8'h04, A_COUNT = 8'h08, A_PRE = 8'h0C;
    localparam logic [7:0] A_CMP = 8'h10, A_CAP = 8'h20;

    ptmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_strobe(cap_strobe), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge; one rising edge commits the write.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic zero_counters();
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_FLAGS, v); check("R1", "flags", v, 0);
        rd(A_CTRL, v);  check("R1", "ctrl", v, 0);
        rd(A_COUNT, v); check("R1", "count", v, 0);
        rd(A_PRE, v);   check("R1", "prescale", v, 0);
        rd(A_CAP, v);   check("R1", "capture0", v, 0);
        check("R1", "irq", {31'b0, irq}, 0);
    endtask

    task automatic t_ctrl_next_clock();
        logic [31:0] v;
        wr(A_PRE, 0);
        wr(A_CTRL, 32'h1);
        rd(A_COUNT, v); check("R12", "count right after enable", v, 0);
        wait_clk(1);
        rd(A_COUNT, v); check("R12", "count one clock later", v, 1);
        wait_clk(2);
        rd(A_COUNT, v); check("R3", "P=0 every clock", v, 3);
        wr(A_CTRL, 0);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        zero_counters();
        wr(A_PRE, 3);
        wr(A_CTRL, 32'h1);
        wait_clk(19);
        rd(A_COUNT, v); check("R3", "P=3 after 19 clocks", v, 4);
        wait_clk(1);
        rd(A_COUNT, v); check("R3", "P=3 after 20 clocks", v, 5);
        wr(A_CTRL, 0);
        wr(A_PRE, 0);
    endtask

    task automatic t_hold();
        logic [31:0] a, b;
        rd(A_COUNT, a);
        wait_clk(10);
        rd(A_COUNT, b); check("R4", "count held while disabled", b, a);
    endtask

    task automatic t_held_clear();
        logic [31:0] v;
        wr(A_CTRL, 32'h1);
        wait_clk(3);
        wr(A_CTRL, 32'h3);
        wait_clk(5);
        rd(A_COUNT, v); check("R5", "count held at zero", v, 0);
        wr(A_CTRL, 32'h1);
        wait_clk(3);
        rd(A_COUNT, v); check("R5", "count resumes from zero", v, 3);
        wr(A_CTRL, 0);
    endtask

    task automatic t_match();
        logic [31:0] v;
        zero_counters();
        wr(A_FLAGS, 32'hFF);
        wr(A_CMP + 8'h4, 5);
        wr(A_CTRL, 32'h1);
        wait_clk(4);
        rd(A_FLAGS, v); check("R7", "no flag before match", v, 0);
        check("R11", "irq low with no flag", {31'b0, irq}, 0);
        wait_clk(1);
        rd(A_FLAGS, v); check("R7", "compare 1 flag", v, 32'h02);
        check("R11", "irq high with flag", {31'b0, irq}, 1);
        wr(A_CTRL, 0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(A_FLAGS, 32'h0);
        rd(A_FLAGS, v); check("R9", "write 0 keeps flag", v, 32'h02);
        wr(A_FLAGS, 32'h02);
        rd(A_FLAGS, v); check("R9", "write 1 clears flag", v, 0);
        check("R11", "irq drops after clear", {31'b0, irq}, 0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        for (int k = 0; k < 4; k++) wr(A_CMP + 8'(4 * k), 32'h100 + k);
        wr(A_FLAGS, 32'hFF);
        wr(A_COUNT, 32'hFFFF_FFFE);
        wr(A_CTRL, 32'h1);
        wait_clk(1);
        rd(A_COUNT, v); check("R6", "top value", v, 32'hFFFF_FFFF);
        wait_clk(1);
        rd(A_COUNT, v); check("R6", "wrapped to zero", v, 0);
        rd(A_FLAGS, v); check("R6", "no flag on wrap", v, 0);
        wr(A_CTRL, 0);
    endtask

    task automatic t_capture();
        logic [31:0] t, v;
        wr(A_FLAGS, 32'hFF);
        wr(A_CTRL, 32'h1);
        wait_clk(2);
        rd(A_COUNT, t);
        cap_strobe = 4'b0001;
        @(negedge clk);
        cap_strobe = 4'b0000;
        rd(A_CAP, v);   check("R8", "capture0 value", v, t);
        rd(A_FLAGS, v); check("R8", "capture0 flag bit 4", v, 32'h10);
        wr(A_CTRL, 0);
        wr(A_FLAGS, 32'hFF);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_FLAGS; bus_wdata = 32'h40;
        cap_strobe = 4'b0100;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; cap_strobe = 4'b0000;
        rd(A_FLAGS, v); check("R10", "set beats clear", v, 32'h40);
        wr(A_FLAGS, 32'h40);
        rd(A_FLAGS, v); check("R10", "later clear works", v, 0);
    endtask

    task automatic t_map();
        logic [31:0] v, c0;
        wr(A_CMP + 8'h8, 32'hA5A5_1234);
        rd(A_CMP + 8'h8, v); check("R2", "compare 2 readback", v, 32'hA5A5_1234);
        wr(A_PRE, 32'h0000_0777);
        rd(A_PRE, v); check("R2", "prescale readback", v, 32'h0000_0777);
        rd(A_CAP, c0);
        wr(A_CAP, 32'hDEAD_BEEF);
        rd(A_CAP, v); check("R2", "capture write ignored", v, c0);
        rd(A_CTRL, v); check("R2", "control readback", v, 0);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_next_clock();
        t_prescale();
        t_hold();
        t_held_clear();
        t_match();
        t_clear();
        t_wrap();
        t_capture();
        t_set_wins();
        t_map();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule